// File: doc/BRIEF.md
# Byte-Stream Matrix Loader

This block sits at the front of a small 2x2 multiply-accumulate array. A narrow host port delivers one byte per clock, qualified by a valid strobe and a two-bit mode. The loader packs those bytes into sixteen-bit words, such as bfloat16 values. It writes them either into a weight set or into an input set, and each set holds four words. Bytes carry no address. Two internal position counters, one per set, decide where each byte lands. Each counter moves forward only on accepted bytes of its own kind.

Weights are meant to be loaded once and reused across many input matrices. Input words are reloaded for every matrix. A word-ready pulse marks the point where each word becomes complete, so the compute side can begin on an element while the rest of the matrix is still arriving. A matrix-done pulse marks the final input byte. If a host abandons a transfer part way through, it sends in-band commands that return either counter to its start.

Top module: `mtx_byte_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, both position counters, all eight stored words and all pulse outputs become zero on that edge.
- R2: A valid cycle with mode 0 stores the byte into the weight set at the weight position, then advances that position. Position p writes bits [8p+7:8p] of `wgt_o`, so element k occupies bits [16k+15:16k] with its low byte sent first. Elements arrive in the order (0,0), (1,0), (0,1), (1,1).
- R3: A valid cycle with mode 1 does the same for `inp_o`, using the data position.
- R4: When `in_vld` is low, no stored word and no position changes. A transfer that pauses resumes at the byte where it stopped.
- R5: The weight and data positions are independent. A weight byte never moves the data position, and a data byte never moves the weight position.
- R6: A valid cycle with mode 3 returns both positions to 0. The data byte is ignored, and no stored word changes.
- R7: A valid cycle with mode 2 resets one position, chosen by `in_byte[0]`. A value of 1 selects the weight position and 0 selects the data position. The other byte bits are ignored, and no stored word changes.
- R8: A position at 7 wraps to 0 after it accepts a byte.
- R9: `wgt_rdy[k]` (`inp_rdy[k]`) is high for exactly the one cycle after the edge that stores the high byte of weight (input) element k. At most one bit of each vector is high, and no bit is high two cycles in a row.
- R10: `mat_done` is high for the one cycle after the edge that stores the eighth input byte, meaning the byte written at data position 7.
- R11: Stored weights do not change until weight bytes overwrite them, whatever input, command or idle traffic comes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Qualifies the byte and the mode |
| in_mode | input | 2 | 0 weight byte, 1 input byte, 2 single position reset, 3 reset both positions |
| in_byte | input | 8 | Payload byte; bit 0 selects the target under mode 2 |
| wgt_o | output | 64 | Four stored weight words, element k at [16k+15:16k] |
| inp_o | output | 64 | Four stored input words, element k at [16k+15:16k] |
| wgt_rdy | output | 4 | One-cycle pulse per completed weight word |
| inp_rdy | output | 4 | One-cycle pulse per completed input word |
| mat_done | output | 1 | One-cycle pulse after the last input byte of a matrix |

## Verification
Some properties are checked by assertions on every cycle. Idle cycles leave both word sets frozen, and cycles that carry no weight byte leave the weights frozen. The ready vectors are never more than one-hot and never fire on two consecutive cycles. `mat_done` always coincides with readiness of the last input element. Other behaviour can only be shown by the bench's scenarios. These scenarios cover the byte placement, low byte first, and the resume point after a pause. They also cover which position each reset command hits and the wrap from 7 back to 0. In each case the outputs are compared against a model that follows the stream byte by byte.

// File: rtl/mtx_byte_loader.sv
module mtx_byte_loader #(
  parameter int ELEMS  = 4,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [1:0]              in_mode,
  input  logic [BYTE_W-1:0]       in_byte,
  output logic [ELEMS*WORD_W-1:0] wgt_o,
  output logic [ELEMS*WORD_W-1:0] inp_o,
  output logic [ELEMS-1:0]        wgt_rdy,
  output logic [ELEMS-1:0]        inp_rdy,
  output logic                    mat_done
);
  localparam int BPW   = WORD_W / BYTE_W;
  localparam int SLOTS = ELEMS * BPW;
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  logic [IW-1:0] w_idx, d_idx;
  logic wr_w, wr_d, clr_w, clr_d;

  assign wr_w  = in_vld && (in_mode == 2'd0);
  assign wr_d  = in_vld && (in_mode == 2'd1);
  assign clr_w = in_vld && ((in_mode == 2'd3) || ((in_mode == 2'd2) &&  in_byte[0]));
  assign clr_d = in_vld && ((in_mode == 2'd3) || ((in_mode == 2'd2) && !in_byte[0]));

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_idx    <= '0;
      d_idx    <= '0;
      wgt_o    <= '0;
      inp_o    <= '0;
      wgt_rdy  <= '0;
      inp_rdy  <= '0;
      mat_done <= 1'b0;
    end else begin
      wgt_rdy  <= '0;
      inp_rdy  <= '0;
      mat_done <= 1'b0;
      if (clr_w) begin
        w_idx <= '0;
      end else if (wr_w) begin
        wgt_o[int'(w_idx)*BYTE_W +: BYTE_W] <= in_byte;
        w_idx <= bump(w_idx);
        if (int'(w_idx) % BPW == BPW - 1) wgt_rdy[int'(w_idx) / BPW] <= 1'b1;
      end
      if (clr_d) begin
        d_idx <= '0;
      end else if (wr_d) begin
        inp_o[int'(d_idx)*BYTE_W +: BYTE_W] <= in_byte;
        d_idx <= bump(d_idx);
        if (int'(d_idx) % BPW == BPW - 1) inp_rdy[int'(d_idx) / BPW] <= 1'b1;
        mat_done <= (d_idx == LAST);
      end
    end
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(wgt_o) && $stable(inp_o)); // R4
  AST_WGT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode != 2'd0) |=> $stable(wgt_o)); // R11
  AST_RDY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgt_rdy) && $onehot0(inp_rdy)); // R9
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wgt_rdy != '0 || inp_rdy != '0) |=> (wgt_rdy & $past(wgt_rdy)) == '0 && (inp_rdy & $past(inp_rdy)) == '0); // R9
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    mat_done |-> inp_rdy[ELEMS-1]); // R10
  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode[1]) |=> $stable(wgt_o) && $stable(inp_o)); // R6
endmodule

// File: tb/tb_mtx_byte_loader.sv
module tb_mtx_byte_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [1:0]  in_mode;
  logic [7:0]  in_byte;
  logic [63:0] wgt_o, inp_o;
  logic [3:0]  wgt_rdy, inp_rdy;
  logic        mat_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] em_w, em_d;
  logic [3:0]  ex_wr, ex_ir;
  logic        ex_done;
  int wi, di;

  mtx_byte_loader dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode), .in_byte(in_byte),
    .wgt_o(wgt_o), .inp_o(inp_o), .wgt_rdy(wgt_rdy), .inp_rdy(inp_rdy), .mat_done(mat_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(wgt_o == em_w,   {tag, " wgt_o"},    wgt_o, em_w);
    chk(inp_o == em_d,   {tag, " inp_o"},    inp_o, em_d);
    chk(wgt_rdy == ex_wr, {tag, " R9 wgt_rdy"}, 64'(wgt_rdy), 64'(ex_wr));
    chk(inp_rdy == ex_ir, {tag, " R9 inp_rdy"}, 64'(inp_rdy), 64'(ex_ir));
    chk(mat_done == ex_done, {tag, " R10 mat_done"}, 64'(mat_done), 64'(ex_done));
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic [7:0] b, input string tag);
    ex_wr = '0; ex_ir = '0; ex_done = 1'b0;
    if (v) begin
      case (m)
        2'd0: begin
          em_w[wi*8 +: 8] = b;
          if (wi % 2 == 1) ex_wr[wi/2] = 1'b1;
          wi = (wi + 1) % 8;
        end
        2'd1: begin
          em_d[di*8 +: 8] = b;
          if (di % 2 == 1) ex_ir[di/2] = 1'b1;
          if (di == 7) ex_done = 1'b1;
          di = (di + 1) % 8;
        end
        2'd2: if (b[0]) wi = 0; else di = 0;
        default: begin wi = 0; di = 0; end
      endcase
    end
    in_vld = v; in_mode = m; in_byte = b;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; in_vld = 1'b1; in_mode = 2'd0; in_byte = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    em_w = '0; em_d = '0; wi = 0; di = 0;
    ex_wr = '0; ex_ir = '0; ex_done = 1'b0;
    check_all(tag);
    rst_n = 1'b1; in_vld = 1'b0;
  endtask

  task automatic send_word(input logic [1:0] m, input logic [15:0] w, input string tag);
    step(1'b1, m, w[7:0], tag);
    step(1'b1, m, w[15:8], tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1..watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_mode = 2'd0; in_byte = 8'h00;
    em_w = '0; em_d = '0; wi = 0; di = 0;
    @(negedge clk);
    do_reset("R1 reset state");

    send_word(2'd0, 16'h3F80, "R2 weight e0");
    send_word(2'd0, 16'h4000, "R2 weight e1");
    send_word(2'd0, 16'h4040, "R2 weight e2");
    send_word(2'd0, 16'h4080, "R2 R8 weight e3");

    send_word(2'd1, 16'h40A0, "R3 input e0");
    step(1'b1, 2'd1, 8'hC0, "R3 input e1 low");
    step(1'b0, 2'd1, 8'hEE, "R4 pause");
    step(1'b0, 2'd0, 8'h77, "R4 pause");
    step(1'b0, 2'd3, 8'h11, "R4 pause");
    step(1'b1, 2'd1, 8'h40, "R4 resume e1 high");
    step(1'b1, 2'd1, 8'hE0, "R5 input e2 low");
    step(1'b1, 2'd0, 8'h12, "R5 weight between inputs");
    step(1'b1, 2'd1, 8'h40, "R5 input e2 high");
    send_word(2'd1, 16'h4100, "R10 input e3");
    chk(wgt_o[63:16] == 64'h4080_4040_4000, "R11 weights kept", {16'h0, wgt_o[63:16]}, 64'h4080_4040_4000);
    send_word(2'd1, 16'h1234, "R8 data wrap to e0");

    step(1'b1, 2'd1, 8'h55, "R6 mid data");
    step(1'b1, 2'd3, 8'hFF, "R6 reset both");
    step(1'b1, 2'd1, 8'h66, "R6 data restarts at 0");
    step(1'b1, 2'd0, 8'h99, "R6 weight restarts at 0");

    step(1'b1, 2'd0, 8'h21, "R7 weight byte");
    step(1'b1, 2'd1, 8'h31, "R7 data byte");
    step(1'b1, 2'd2, 8'hFE, "R7 reset data only");
    step(1'b1, 2'd1, 8'h41, "R7 data at 0");
    step(1'b1, 2'd0, 8'h51, "R7 weight unmoved");
    step(1'b1, 2'd2, 8'h01, "R7 reset weight only");
    step(1'b1, 2'd0, 8'h61, "R7 weight at 0");
    step(1'b1, 2'd1, 8'h71, "R7 data unmoved");

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [1:0] m;
      int r;
      v = ($urandom % 4) != 0;
      r = $urandom % 16;
      m = (r < 7) ? 2'd0 : (r < 14) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
      step(v, m, 8'($urandom), "R2 R3 R4 R5 R6 R7 R8 R11 random");
      if (n == 1500) do_reset("R1 reset mid run");
    end

    step(1'b0, 2'd0, 8'h00, "R4 final idle");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule